// File: doc/BRIEF.md
# AC-link input status and microphone slot capture

This block sits behind the deserializer of a two-codec AC-link controller. The deserializer hands it one 20-bit word for each input slot, with a strobe, the slot number and the codec the word came from. It also gives an end-of-frame strobe. The block keeps one copy of the general-purpose-input status word for each codec, taken from slot 12 of every frame. It serves local register reads of that status without putting a command on the link. It raises a sticky interrupt when a codec flags an input change. It also picks the 16-bit microphone sample out of slot 6.

In every slot word the 16-bit payload is left-justified in bits 19:4, and bits 3:0 are dropped. The input tag arrives in slot 0. Its bit for slot n sits at word bit 19-n, so the slot 6 valid flag is word bit 13. A register read at a status offset is answered by the block one cycle later. A read at any other offset is passed on, one cycle later, as a link command request for the command path.

Top module: `aclink_gpi_capture`

## Requirements
- R1: After reset the status copies of both codecs read as zero, and irq, micValid, rdValid and cmdFwd are low.
- R2: Every slot 12 strobe loads slotData[19:4] into the status copy of the codec named by slotCodec, whatever the tag says. The new value is readable from the next cycle, and slotData[3:0] is discarded.
- R3: A read (regRd) at 0x54 returns the codec 0 status, and a read at 0xD4 returns the codec 1 status. The result comes on rdData with a one-cycle rdValid pulse in the next cycle, carrying the value held at the start of the read cycle. cmdFwd stays low.
- R4: A read at any other offset gives a one-cycle cmdFwd pulse in the next cycle, with cmdAddr equal to the read offset. No rdValid is produced.
- R5: The change flag is bit 0 of the status field, which is slotData[4] of slot 12. When a slot 12 word carries this flag while gpiIntEn is high, irq is high from the next cycle. With gpiIntEn low, the flag leaves irq unchanged.
- R6: irq is sticky. It stays high until an intClr pulse lowers it in the following cycle. If a flagged slot 12 and intClr come in the same cycle, irq stays set.
- R7: A slot 6 strobe produces micValid for one cycle in the next cycle, with micData = slotData[19:4] and micSrc = slotCodec. This happens only if that codec's most recent slot 0 in the current frame had bit 13 set. That codec's frameEnd forgets the flag.
- R8: Words in slots 1 to 5 and 7 to 11 change no output and no status copy.
- R9: The status copy of one codec is never altered by slots from the other codec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotStb | input | 1 | A deserialized slot word is present |
| slotNum | input | 4 | Slot number of the word |
| slotCodec | input | 1 | Codec that sent the word or the frame end |
| slotData | input | 20 | Slot word |
| frameEnd | input | 1 | End of the frame from slotCodec |
| regRd | input | 1 | Register read request |
| regAddr | input | 8 | Register read offset |
| rdValid | output | 1 | Locally served read result is valid |
| rdData | output | 16 | Locally served read result |
| cmdFwd | output | 1 | Read must go to the link as a command |
| cmdAddr | output | 8 | Offset of the forwarded read |
| gpiIntEn | input | 1 | Interrupt enable from global control |
| intClr | input | 1 | Write-one-to-clear strobe for the interrupt |
| irq | output | 1 | Sticky change interrupt |
| micValid | output | 1 | Microphone sample strobe |
| micData | output | 16 | Microphone sample |
| micSrc | output | 1 | Codec that sent the sample |

## Verification
A corrupted status copy does not show by itself. It becomes visible at the next local read, one cycle after regRd, so the bench reads both offsets after every frame that could have touched them. A wrongly kept or lost slot 6 valid flag shows as a missing or extra micValid one cycle after the slot 6 strobe. A wrong interrupt state shows on irq in the cycle after the flagged slot or after the clear.

// File: rtl/gpi_cap_pkg.sv
package gpi_cap_pkg;
  localparam int NUM_CODEC  = 2;
  localparam int CODEC_W    = (NUM_CODEC > 1) ? $clog2(NUM_CODEC) : 1;
  localparam int SLOT_NUM_W = 4;
  localparam int SLOT_TAG   = 0;
  localparam int SLOT_MIC   = 6;
  localparam int SLOT_GPI   = 12;

  typedef struct packed {
    logic [NUM_CODEC-1:0] gpiLoad;
    logic                 micLoad;
    logic [CODEC_W-1:0]   micCodec;
    logic                 rdLocal;
    logic [CODEC_W-1:0]   rdCodec;
    logic                 rdFwd;
  } ctlStrobes_t;
endpackage

// File: rtl/gpi_cap_ctrl.sv
module gpi_cap_ctrl
  import gpi_cap_pkg::*;
#(
  parameter int SLOT_W       = 20,
  parameter int SAMPLE_W     = 16,
  parameter int ADDR_W       = 8,
  parameter int GPI_OFS      = 'h54,
  parameter int CODEC_STRIDE = 'h80
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  slotStb,
  input  logic [SLOT_NUM_W-1:0] slotNum,
  input  logic [CODEC_W-1:0]    slotCodec,
  input  logic [SLOT_W-1:0]     slotData,
  input  logic                  frameEnd,
  input  logic                  regRd,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  gpiIntEn,
  input  logic                  intClr,
  output ctlStrobes_t           ctl,
  output logic                  irq
);
  localparam int TAG_BIT  = SLOT_W - 1 - SLOT_MIC;
  localparam int FLAG_BIT = SLOT_W - SAMPLE_W;

  logic [NUM_CODEC-1:0] micTag;
  logic [NUM_CODEC-1:0] localHit;
  logic                 isGpi;
  logic                 isMic;
  logic                 isTag;
  logic                 changeSeen;
  logic                 intSts;

  assign isGpi = slotStb && (slotNum == SLOT_NUM_W'(SLOT_GPI));
  assign isMic = slotStb && (slotNum == SLOT_NUM_W'(SLOT_MIC));
  assign isTag = slotStb && (slotNum == SLOT_NUM_W'(SLOT_TAG));
  assign changeSeen = isGpi && slotData[FLAG_BIT] && gpiIntEn;

  for (genvar k = 0; k < NUM_CODEC; k++) begin : gCodec
    always_ff @(posedge clk) begin
      if (!rstN) begin
        micTag[k] <= 1'b0;
      end else if (isTag && slotCodec == CODEC_W'(k)) begin
        micTag[k] <= slotData[TAG_BIT];
      end else if (frameEnd && slotCodec == CODEC_W'(k)) begin
        micTag[k] <= 1'b0;
      end
    end
    assign localHit[k] = regRd && (regAddr == ADDR_W'(GPI_OFS + k * CODEC_STRIDE));
  end

  always_comb begin
    ctl = '0;
    for (int k = 0; k < NUM_CODEC; k++) begin
      ctl.gpiLoad[k] = isGpi && (slotCodec == CODEC_W'(k));
      if (localHit[k]) ctl.rdCodec = CODEC_W'(k);
    end
    ctl.micLoad  = isMic && micTag[slotCodec];
    ctl.micCodec = slotCodec;
    ctl.rdLocal  = |localHit;
    ctl.rdFwd    = regRd && !(|localHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intSts <= 1'b0;
    end else if (changeSeen) begin
      intSts <= 1'b1;
    end else if (intClr) begin
      intSts <= 1'b0;
    end
  end
  assign irq = intSts;

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !intClr) |=> irq);
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && !(isGpi && slotData[FLAG_BIT] && gpiIntEn)) |=> !irq);
endmodule

// File: rtl/gpi_cap_dp.sv
module gpi_cap_dp
  import gpi_cap_pkg::*;
#(
  parameter int SLOT_W   = 20,
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SLOT_W-1:0]   slotData,
  input  logic [ADDR_W-1:0]   regAddr,
  input  ctlStrobes_t         ctl,
  output logic                rdValid,
  output logic [SAMPLE_W-1:0] rdData,
  output logic                cmdFwd,
  output logic [ADDR_W-1:0]   cmdAddr,
  output logic                micValid,
  output logic [SAMPLE_W-1:0] micData,
  output logic [CODEC_W-1:0]  micSrc
);
  logic [SAMPLE_W-1:0] payload;
  logic [SAMPLE_W-1:0] gpiReg [NUM_CODEC];

  assign payload = slotData[SLOT_W-1 -: SAMPLE_W];

  for (genvar k = 0; k < NUM_CODEC; k++) begin : gStat
    always_ff @(posedge clk) begin
      if (!rstN) begin
        gpiReg[k] <= '0;
      end else if (ctl.gpiLoad[k]) begin
        gpiReg[k] <= payload;
      end
    end
    a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.gpiLoad[k] |=> $stable(gpiReg[k]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdData   <= '0;
      cmdFwd   <= 1'b0;
      cmdAddr  <= '0;
      micValid <= 1'b0;
      micData  <= '0;
      micSrc   <= '0;
    end else begin
      rdValid  <= ctl.rdLocal;
      cmdFwd   <= ctl.rdFwd;
      micValid <= ctl.micLoad;
      if (ctl.rdLocal) rdData <= gpiReg[ctl.rdCodec];
      if (ctl.rdFwd) cmdAddr <= regAddr;
      if (ctl.micLoad) begin
        micData <= payload;
        micSrc  <= ctl.micCodec;
      end
    end
  end
endmodule

// File: rtl/aclink_gpi_capture.sv
module aclink_gpi_capture
  import gpi_cap_pkg::*;
#(
  parameter int SLOT_W       = 20,
  parameter int SAMPLE_W     = 16,
  parameter int ADDR_W       = 8,
  parameter int GPI_OFS      = 'h54,
  parameter int CODEC_STRIDE = 'h80
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  slotStb,
  input  logic [SLOT_NUM_W-1:0] slotNum,
  input  logic [CODEC_W-1:0]    slotCodec,
  input  logic [SLOT_W-1:0]     slotData,
  input  logic                  frameEnd,
  input  logic                  regRd,
  input  logic [ADDR_W-1:0]     regAddr,
  output logic                  rdValid,
  output logic [SAMPLE_W-1:0]   rdData,
  output logic                  cmdFwd,
  output logic [ADDR_W-1:0]     cmdAddr,
  input  logic                  gpiIntEn,
  input  logic                  intClr,
  output logic                  irq,
  output logic                  micValid,
  output logic [SAMPLE_W-1:0]   micData,
  output logic [CODEC_W-1:0]    micSrc
);
  ctlStrobes_t ctl;

  gpi_cap_ctrl #(
    .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W),
    .GPI_OFS(GPI_OFS), .CODEC_STRIDE(CODEC_STRIDE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .slotNum(slotNum),
    .slotCodec(slotCodec), .slotData(slotData), .frameEnd(frameEnd),
    .regRd(regRd), .regAddr(regAddr), .gpiIntEn(gpiIntEn), .intClr(intClr),
    .ctl(ctl), .irq(irq)
  );

  gpi_cap_dp #(
    .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .slotData(slotData), .regAddr(regAddr), .ctl(ctl),
    .rdValid(rdValid), .rdData(rdData), .cmdFwd(cmdFwd), .cmdAddr(cmdAddr),
    .micValid(micValid), .micData(micData), .micSrc(micSrc)
  );

  a_r3_local_no_cmd: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !cmdFwd);
  a_r4_fwd_addr: assert property (@(posedge clk) disable iff (!rstN)
    cmdFwd |-> (cmdAddr == $past(regAddr)));
  a_r7_mic_from_slot6: assert property (@(posedge clk) disable iff (!rstN)
    micValid |-> $past(slotStb && slotNum == SLOT_NUM_W'(SLOT_MIC)));
endmodule

// File: tb/sim_aclink_gpi_capture.sv
module sim_aclink_gpi_capture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slotStb = 1'b0;
  logic [3:0]  slotNum = '0;
  logic [0:0]  slotCodec = '0;
  logic [19:0] slotData = '0;
  logic        frameEnd = 1'b0;
  logic        regRd = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        gpiIntEn = 1'b0;
  logic        intClr = 1'b0;
  logic        rdValid, cmdFwd, irq, micValid;
  logic [15:0] rdData, micData;
  logic [7:0]  cmdAddr;
  logic [0:0]  micSrc;

  int nRun = 0;
  int nFail = 0;
  logic [31:0] expRd [$];
  logic [31:0] expFwd [$];
  logic [31:0] expMic [$];

  always #5 clk = ~clk;

  aclink_gpi_capture u0 (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .slotNum(slotNum),
    .slotCodec(slotCodec), .slotData(slotData), .frameEnd(frameEnd),
    .regRd(regRd), .regAddr(regAddr), .rdValid(rdValid), .rdData(rdData),
    .cmdFwd(cmdFwd), .cmdAddr(cmdAddr), .gpiIntEn(gpiIntEn), .intClr(intClr),
    .irq(irq), .micValid(micValid), .micData(micData), .micSrc(micSrc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare every produced result against the scoreboard
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expRd.size() == 0) chk(1'b0, "R3 unexpected rdValid", {16'h0, rdData}, 32'h0);
      else begin
        logic [31:0] e;
        e = expRd.pop_front();
        chk({16'h0, rdData} == e, "R3 local read data", {16'h0, rdData}, e);
      end
    end
    if (rstN && cmdFwd) begin
      if (expFwd.size() == 0) chk(1'b0, "R4 unexpected cmdFwd", {24'h0, cmdAddr}, 32'h0);
      else begin
        logic [31:0] e;
        e = expFwd.pop_front();
        chk({24'h0, cmdAddr} == e, "R4 forwarded address", {24'h0, cmdAddr}, e);
      end
    end
    if (rstN && micValid) begin
      if (expMic.size() == 0) chk(1'b0, "R7 unexpected micValid", {15'h0, micSrc, micData}, 32'h0);
      else begin
        logic [31:0] e;
        e = expMic.pop_front();
        chk({15'h0, micSrc, micData} == e, "R7 mic sample", {15'h0, micSrc, micData}, e);
      end
    end
  end

  task automatic sendSlot(input logic c, input int n, input logic [19:0] d);
    @(posedge clk) #1;
    slotStb = 1'b1; slotNum = 4'(n); slotCodec = c; slotData = d;
    @(posedge clk) #1;
    slotStb = 1'b0; slotData = '0;
  endtask

  task automatic endFrame(input logic c);
    @(posedge clk) #1;
    frameEnd = 1'b1; slotCodec = c;
    @(posedge clk) #1;
    frameEnd = 1'b0;
  endtask

  task automatic readLocal(input logic [7:0] a, input logic [15:0] e);
    expRd.push_back({16'h0, e});
    @(posedge clk) #1;
    regRd = 1'b1; regAddr = a;
    @(posedge clk) #1;
    regRd = 1'b0;
    @(posedge clk) #1;
  endtask

  task automatic readFwd(input logic [7:0] a);
    expFwd.push_back({24'h0, a});
    @(posedge clk) #1;
    regRd = 1'b1; regAddr = a;
    @(posedge clk) #1;
    regRd = 1'b0;
    @(posedge clk) #1;
  endtask

  task automatic pulseClr();
    @(posedge clk) #1;
    intClr = 1'b1;
    @(posedge clk) #1;
    intClr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk) #1;
    // R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);
    chk(micValid == 1'b0, "R1 micValid after reset", {31'h0, micValid}, 32'h0);
    chk(rdValid == 1'b0, "R1 rdValid after reset", {31'h0, rdValid}, 32'h0);
    chk(cmdFwd == 1'b0, "R1 cmdFwd after reset", {31'h0, cmdFwd}, 32'h0);
    readLocal(8'h54, 16'h0000);   // R1
    readLocal(8'hD4, 16'h0000);   // R1

    // codec 0 frame: mic valid, reserved slots nonzero (R2, R7, R8)
    sendSlot(1'b0, 0, 20'h82000);
    for (int s = 1; s <= 5; s++) sendSlot(1'b0, s, 20'hFFFFF);
    expMic.push_back({15'h0, 1'b0, 16'hABCD});
    sendSlot(1'b0, 6, 20'hABCD5);
    for (int s = 7; s <= 11; s++) sendSlot(1'b0, s, 20'hFFFFF);
    sendSlot(1'b0, 12, 20'h12340);
    endFrame(1'b0);
    readLocal(8'h54, 16'h1234);   // R2
    chk(irq == 1'b0, "R5 no flag no irq", {31'h0, irq}, 32'h0);

    // codec 1 frame: slot 6 not tagged, flagged status with enable off (R5, R7, R9)
    sendSlot(1'b1, 0, 20'h80000);
    sendSlot(1'b1, 6, 20'h55555);
    sendSlot(1'b1, 12, 20'hBEEF7);
    chk(irq == 1'b0, "R5 flag with enable low", {31'h0, irq}, 32'h0);
    endFrame(1'b1);
    readLocal(8'hD4, 16'hBEEF);   // R2 low nibble dropped
    readLocal(8'h54, 16'h1234);   // R9 other codec untouched

    // forwarded reads (R4)
    readFwd(8'h10);
    readFwd(8'h55);
    readFwd(8'hD6);

    // interrupt (R5, R6)
    gpiIntEn = 1'b1;
    sendSlot(1'b0, 12, 20'h0001F);
    chk(irq == 1'b1, "R5 irq set by flag", {31'h0, irq}, 32'h1);
    endFrame(1'b0);
    sendSlot(1'b0, 12, 20'h00020);
    chk(irq == 1'b1, "R6 irq sticky", {31'h0, irq}, 32'h1);
    readLocal(8'h54, 16'h0002);   // R2 latest frame
    pulseClr();
    chk(irq == 1'b0, "R6 irq cleared", {31'h0, irq}, 32'h0);
    // flag and clear together: set wins
    @(posedge clk) #1;
    slotStb = 1'b1; slotNum = 4'd12; slotCodec = 1'b1; slotData = 20'h00011; intClr = 1'b1;
    @(posedge clk) #1;
    slotStb = 1'b0; intClr = 1'b0; slotData = '0;
    chk(irq == 1'b1, "R6 set wins over clear", {31'h0, irq}, 32'h1);
    pulseClr();
    chk(irq == 1'b0, "R6 clear again", {31'h0, irq}, 32'h0);

    // reserved slots alone change nothing (R8)
    for (int s = 7; s <= 11; s++) sendSlot(1'b1, s, 20'hA5A5A);
    readLocal(8'hD4, 16'h0001);   // R8
    readLocal(8'h54, 16'h0002);   // R8
    chk(irq == 1'b0, "R8 irq unchanged", {31'h0, irq}, 32'h0);

    // tag forgotten at frame end (R7)
    sendSlot(1'b1, 0, 20'h82000);
    expMic.push_back({15'h0, 1'b1, 16'h1357});
    sendSlot(1'b1, 6, 20'h13579);
    endFrame(1'b1);
    sendSlot(1'b1, 6, 20'h24680);  // no tag in new frame: no sample
    // tag on codec 0 does not enable codec 1 slot 6
    sendSlot(1'b0, 0, 20'h82000);
    sendSlot(1'b1, 6, 20'h99990);
    expMic.push_back({15'h0, 1'b0, 16'h7777});
    sendSlot(1'b0, 6, 20'h77770);
    repeat (3) @(posedge clk);
    #1;
    chk(expRd.size() == 0, "R3 all reads answered", expRd.size(), 0);
    chk(expFwd.size() == 0, "R4 all forwards seen", expFwd.size(), 0);
    chk(expMic.size() == 0, "R7 all samples seen", expMic.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule